// File: doc/BRIEF.md
# External Interrupt Request Detector

This block watches a set of external request pins, one per channel, and turns activity on them into held interrupt causes. Each channel is programmed to react to a low level, a high level, a rising edge or a falling edge on its pin. A detected event sets that channel's cause flag. The flag stays set after the pin returns to idle, until software clears it. The request that goes to the interrupt controller is the cause flag gated by the channel's enable bit. The same channels can serve as transfer requests from a peripheral. Such a peripheral must drop its request soon after the transfer starts, or the channel detects the request again.

Every pin passes through a two-flop synchronizer. In edge modes a glitch filter then requires the new level to be present for three clock cycles before an edge counts. A separate wake output is built without any clock. It is asserted while any enabled channel that is set for high level sees its raw pin high, so it can bring the part out of a clock-stopped standby. Software reaches the enable, cause and level-select registers through a small word-wide register port that has per-half byte-lane strobes.

Top module: `ext_req_detector`

## Requirements
- R1: After reset all enable bits and all cause bits are 0, every level-select field reads 2'b10 (rising edge), every interrupt request is 0 and the wake output is 0.
- R2: Once a channel's cause bit is set, it stays 1 after the pin returns to idle. It clears only when software writes a 0 to it.
- R3: Each interrupt request output bit is 1 exactly when that channel's cause bit and enable bit are both 1. It drops in the cycle after either bit is cleared.
- R4: In level mode (field 2'b00 means low, 2'b01 means high), the cause bit is set on every clock edge while the synchronized pin shows that level. The cause bit becomes visible three clock edges after the pin changes.
- R5: In edge mode (field 2'b10 means rising, 2'b11 means falling), one edge is recognised per transition of the required direction. The new level must be held for at least 3 consecutive clock cycles. A pulse of 2 cycles or shorter sets nothing.
- R6: The wake output is combinational and uses no clock. It is 1 exactly when some channel has its raw pin high, its enable bit 1 and its field at 2'b01. Low-level and edge modes never raise it.
- R7: Writing 0 to a cause bit clears it. Writing 1 leaves it unchanged. Writes to a half of a register take effect only when that half's strobe is set (reg_be[0] is the low half, reg_be[1] is the high half).
- R8: A single write to address 0 with both strobes set clears the chosen cause bits and loads the enable bits in the same clock edge.
- R9: A detection in the same cycle as a clear of that cause bit wins, so the bit stays 1. A request that is still held after a clear sets the cause again.
- R10: Address 0 reads {cause[7:0], enable[7:0]}, with the cause bits in [15:8]. Address 1 reads the level-select register, where channel i's field sits at bits [2i+1:2i]. Both registers read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_in | input | 8 | Raw external request pins, one per channel |
| reg_addr | input | 1 | Register select: 0 is enable/cause, 1 is level select |
| reg_we | input | 1 | Write strobe |
| reg_be | input | 2 | Half-word lane strobes |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register (combinational) |
| irq_req | output | 8 | Per-channel requests to the interrupt controller |
| wake_req | output | 1 | Clockless wake-up request |

## Verification
The hardest case to reach is a clear of a cause bit that lands on the same clock edge as a fresh detection on that channel. The bench produces it by holding a high-level request on the pin while it writes zeros to the cause half. After the request drops, it waits out the synchronizer latency and shows that a second clear then sticks. The edge glitch filter boundary is also hard to reach. Table vectors drive pulses of exactly two and exactly three cycles in both edge directions, starting from a settled idle level.

// File: rtl/ext_req_pkg.sv
`timescale 1ns/1ps
package ext_req_pkg;

    // Per-channel sensing mode, two bits per channel in the level-select register
    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_HIGH = 2'b01,
        SENSE_RISE = 2'b10,
        SENSE_FALL = 2'b11
    } sense_e;

    // Register selection on the access port
    typedef enum logic {
        SEL_CTRL  = 1'b0,
        SEL_SENSE = 1'b1
    } reg_sel_e;

    // Mode loaded into every channel by reset (harmless with idle-low pins)
    localparam sense_e RESET_SENSE = SENSE_RISE;

    // Qualified events produced by one channel's front end
    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } pin_evt_t;

    function automatic logic mode_hit(sense_e m, pin_evt_t e);
        logic r;
        case (m)
            SENSE_LOW:  r = ~e.lvl;
            SENSE_HIGH: r =  e.lvl;
            SENSE_RISE: r =  e.rise;
            default:    r =  e.fall;
        endcase
        return r;
    endfunction

    function automatic logic can_wake(sense_e m);
        return m == SENSE_HIGH;
    endfunction

endpackage

// File: rtl/ext_req_sync.sv
`timescale 1ns/1ps
module ext_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ext_req_chan.sv
`timescale 1ns/1ps
module ext_req_chan
    import ext_req_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_PULSE   = 3
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   pin_raw,
    input  sense_e mode,
    output logic   hit,
    output logic   lvl_sync,
    output logic   edge_evt
);
    localparam int CNT_W = (MIN_PULSE > 1) ? $clog2(MIN_PULSE) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MIN_PULSE - 1);

    logic             lvl;
    logic             qual_lvl;   // last level held for MIN_PULSE cycles
    logic [CNT_W-1:0] run_cnt;
    logic             differ;
    logic             qualify;
    pin_evt_t         evt;

    ext_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_raw),
        .q   (lvl)
    );

    // Glitch filter: a new level must persist MIN_PULSE cycles to count
    always_comb begin
        differ  = (lvl != qual_lvl);
        qualify = differ && (run_cnt == CNT_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            qual_lvl <= 1'b0;
            run_cnt  <= '0;
        end else if (!differ) begin
            run_cnt  <= '0;
        end else if (qualify) begin
            qual_lvl <= lvl;
            run_cnt  <= '0;
        end else begin
            run_cnt  <= run_cnt + 1'b1;
        end
    end

    always_comb begin
        evt.lvl  = lvl;
        evt.rise = qualify &  lvl;
        evt.fall = qualify & ~lvl;
        hit      = mode_hit(mode, evt);
    end

    assign lvl_sync = lvl;
    assign edge_evt = qualify;
endmodule

// File: rtl/ext_req_regs.sv
`timescale 1ns/1ps
module ext_req_regs
    import ext_req_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic                 addr,
    input  logic [1:0]           be,
    input  logic [2*NCH-1:0]     wdata,
    input  logic [NCH-1:0]       hit,
    output logic [NCH-1:0]       enable,
    output logic [NCH-1:0]       cause,
    output logic [2*NCH-1:0]     sense,
    output logic [2*NCH-1:0]     rdata
);
    localparam int W = 2 * NCH;
    localparam logic [W-1:0] SENSE_INIT = {NCH{2'(RESET_SENSE)}};

    logic           ctrl_wr;
    logic           sense_wr;
    logic [NCH-1:0] cause_keep;
    logic [NCH-1:0] cause_nxt;

    always_comb begin
        ctrl_wr  = we && (reg_sel_e'(addr) == SEL_CTRL);
        sense_wr = we && (reg_sel_e'(addr) == SEL_SENSE);
        // zero clears, one keeps; a detection this cycle wins
        cause_keep = (ctrl_wr && be[1]) ? (cause & wdata[W-1:NCH]) : cause;
        cause_nxt  = cause_keep | hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enable <= '0;
            cause  <= '0;
        end else begin
            if (ctrl_wr && be[0]) enable <= wdata[NCH-1:0];
            cause <= cause_nxt;
        end
    end

    // Level-select register, written per half
    always_ff @(posedge clk) begin
        if (rst) begin
            sense <= SENSE_INIT;
        end else if (sense_wr) begin
            if (be[0]) sense[NCH-1:0] <= wdata[NCH-1:0];
            if (be[1]) sense[W-1:NCH] <= wdata[W-1:NCH];
        end
    end

    always_comb begin
        if (reg_sel_e'(addr) == SEL_CTRL) rdata = {cause, enable};
        else                              rdata = sense;
    end
endmodule

// File: rtl/ext_req_detector.sv
`timescale 1ns/1ps
module ext_req_detector
    import ext_req_pkg::*;
#(
    parameter int NCH         = 8,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_PULSE   = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NCH-1:0]     ext_in,
    input  logic               reg_addr,
    input  logic               reg_we,
    input  logic [1:0]         reg_be,
    input  logic [2*NCH-1:0]   reg_wdata,
    output logic [2*NCH-1:0]   reg_rdata,
    output logic [NCH-1:0]     irq_req,
    output logic               wake_req
);
    logic [NCH-1:0]   enable;
    logic [NCH-1:0]   cause;
    logic [2*NCH-1:0] sense;
    logic [NCH-1:0]   hit;
    logic [NCH-1:0]   sync_lvl;
    logic [NCH-1:0]   edge_evt;
    logic [NCH-1:0]   wake_vec;

    ext_req_regs #(.NCH(NCH)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (reg_we),
        .addr   (reg_addr),
        .be     (reg_be),
        .wdata  (reg_wdata),
        .hit    (hit),
        .enable (enable),
        .cause  (cause),
        .sense  (sense),
        .rdata  (reg_rdata)
    );

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            sense_e ch_mode;
            assign ch_mode = sense_e'(sense[2*i +: 2]);

            ext_req_chan #(
                .SYNC_STAGES (SYNC_STAGES),
                .MIN_PULSE   (MIN_PULSE)
            ) u_chan (
                .clk      (clk),
                .rst      (rst),
                .pin_raw  (ext_in[i]),
                .mode     (ch_mode),
                .hit      (hit[i]),
                .lvl_sync (sync_lvl[i]),
                .edge_evt (edge_evt[i])
            );

            // Clockless wake path straight from the raw pin
            assign wake_vec[i] = ext_in[i] & enable[i] & can_wake(ch_mode);
        end
    endgenerate

    assign irq_req  = cause & enable;
    assign wake_req = |wake_vec;
endmodule

// File: rtl/ext_req_checker.sv
`timescale 1ns/1ps
module ext_req_checker #(
    parameter int NCH = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               reg_we,
    input logic               reg_addr,
    input logic [1:0]         reg_be,
    input logic [NCH-1:0]     irq_req,
    input logic               wake_req,
    input logic [NCH-1:0]     enable,
    input logic [NCH-1:0]     cause,
    input logic [2*NCH-1:0]   sense,
    input logic [NCH-1:0]     hit,
    input logic [NCH-1:0]     sync_lvl,
    input logic [NCH-1:0]     edge_evt
);
    logic cause_wr;
    logic wake_armed;

    always_comb begin
        cause_wr   = reg_we && !reg_addr && reg_be[1];
        wake_armed = 1'b0;
        for (int i = 0; i < NCH; i++)
            if (enable[i] && sense[2*i +: 2] == 2'b01) wake_armed = 1'b1;
    end

    // R3: no request leaves for a disabled channel
    assert_gate_R3: assert property (@(posedge clk) disable iff (rst)
        (irq_req & ~enable) == '0);

    // R2: a held cause bit falls only after a write to the cause half
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(cause_wr) |-> ((~cause & $past(cause)) == '0));

    // R9: a detection always leaves its cause bit set, even against a clear
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (hit != '0) |=> ((cause & $past(hit)) == $past(hit)));

    // R6: wake stays low unless some enabled channel is in high-level mode
    assert_wake_mode_R6: assert property (@(posedge clk) disable iff (rst)
        !wake_armed |-> !wake_req);

    // R5: an edge needs the synchronized level stable for three cycles
    generate
        for (genvar i = 0; i < NCH; i++) begin : g_edge
            assert_edge_width_R5: assert property (@(posedge clk) disable iff (rst)
                edge_evt[i] |-> (sync_lvl[i] == $past(sync_lvl[i]) &&
                                 $past(sync_lvl[i]) == $past(sync_lvl[i], 2)));
        end
    endgenerate
endmodule

bind ext_req_detector ext_req_checker #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_be   (reg_be),
    .irq_req  (irq_req),
    .wake_req (wake_req),
    .enable   (enable),
    .cause    (cause),
    .sense    (sense),
    .hit      (hit),
    .sync_lvl (sync_lvl),
    .edge_evt (edge_evt)
);

// File: tb/tb_ext_req_detector.sv
`timescale 1ns/1ps
module tb_ext_req_detector;
    localparam int NCH  = 8;
    localparam int NVEC = 10;
    // {channel[9:7], mode[6:5], pulse width[4:1], expected cause[0]}
    localparam logic [9:0] VEC [NVEC] = '{
        {3'd0, 2'b00, 4'd1, 1'b1},   // R4 low level, 1 cycle
        {3'd1, 2'b01, 4'd1, 1'b1},   // R4 high level, 1 cycle
        {3'd2, 2'b10, 4'd2, 1'b0},   // R5 rising, too short
        {3'd2, 2'b10, 4'd3, 1'b1},   // R5 rising, minimum
        {3'd3, 2'b11, 4'd2, 1'b0},   // R5 falling, too short
        {3'd3, 2'b11, 4'd3, 1'b1},   // R5 falling, minimum
        {3'd4, 2'b10, 4'd6, 1'b1},   // R5 rising, long
        {3'd5, 2'b11, 4'd1, 1'b0},   // R5 falling, glitch
        {3'd6, 2'b01, 4'd0, 1'b0},   // R4 high level, no pulse
        {3'd7, 2'b00, 4'd4, 1'b1}    // R4 low level, 4 cycles
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NCH-1:0]  ext_in = '0;
    logic            reg_addr = 1'b0;
    logic            reg_we = 1'b0;
    logic [1:0]      reg_be = 2'b00;
    logic [15:0]     reg_wdata = '0;
    logic [15:0]     reg_rdata;
    logic [NCH-1:0]  irq_req;
    logic            wake_req;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] sense_sh = 16'hAAAA;
    logic [15:0] d;

    always #2.5 clk = ~clk;

    ext_req_detector dut (
        .clk       (clk),
        .rst       (rst),
        .ext_in    (ext_in),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_be    (reg_be),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_req   (irq_req),
        .wake_req  (wake_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [1:0] be, input logic [15:0] v);
        reg_addr = a; reg_be = be; reg_wdata = v; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; reg_be = 2'b00;
    endtask

    task automatic rd(input logic a, output logic [15:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic do_reset();
        ext_in = '0; rst = 1'b1; sense_sh = 16'hAAAA;
        cyc(3);
        rst = 1'b0;
        cyc(1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // ---- reset state (R1)
        cyc(2);
        rd(1'b0, d); check("R1 ctrl reg in reset", d, 16'h0000);
        rd(1'b1, d); check("R1 sense reg in reset", d, 16'hAAAA);
        check("R1 irq in reset", irq_req, 0);
        check("R1 wake in reset", wake_req, 0);
        rst = 1'b0;
        cyc(10);
        rd(1'b0, d); check("R1 no cause after reset", d, 16'h0000);

        // ---- vector table (R4, R5)
        for (int k = 0; k < NVEC; k++) begin
            int ch;
            logic [1:0] m;
            int w;
            logic idle;
            ch = int'(VEC[k][9:7]); m = VEC[k][6:5]; w = int'(VEC[k][4:1]);
            idle = (m == 2'b00) || (m == 2'b11);
            ext_in[ch] = idle; cyc(8);
            sense_sh[2*ch +: 2] = m; wr(1'b1, 2'b11, sense_sh); cyc(8);
            wr(1'b0, 2'b10, 16'h0000); cyc(1);
            if (w != 0) begin
                ext_in[ch] = ~idle;
                cyc(w);
                ext_in[ch] = idle;
            end
            cyc(10);
            rd(1'b0, d);
            if (m[1]) check("R5 edge vector cause", d[15:8], 32'(VEC[k][0]) << ch);
            else      check("R4 level vector cause", d[15:8], 32'(VEC[k][0]) << ch);
        end

        // ---- R5: held edge-mode input gives a single event
        wr(1'b0, 2'b10, 16'h0000);
        ext_in[4] = 1'b0; cyc(8);
        wr(1'b0, 2'b10, 16'h0000);
        ext_in[4] = 1'b1; cyc(8);
        rd(1'b0, d); check("R5 rise on held pin", d[15:8], 8'h10);
        wr(1'b0, 2'b10, 16'h0000); cyc(10);
        rd(1'b0, d); check("R5 no retrigger while held", d[15:8], 8'h00);
        ext_in[4] = 1'b0;

        // ---- R10: register map readback
        wr(1'b1, 2'b11, 16'h1B6C); rd(1'b1, d);
        check("R10 sense readback", d, 16'h1B6C);
        wr(1'b1, 2'b01, 16'hFF00); rd(1'b1, d);
        check("R7 low lane only", d, 16'h1B00);

        // ---- R2 / R3: hold and gating
        do_reset();
        wr(1'b1, 2'b11, 16'hAAA6);                  // ch1 high level
        ext_in[1] = 1'b1; cyc(1); ext_in[1] = 1'b0; cyc(10);
        rd(1'b0, d); check("R2 cause held after pulse", d, 16'h0200);
        check("R3 irq gated while disabled", irq_req, 0);
        wr(1'b0, 2'b01, 16'h0002);
        check("R3 irq with enable", irq_req, 8'h02);
        wr(1'b0, 2'b01, 16'h0000);
        check("R3 irq drops with enable", irq_req, 0);
        rd(1'b0, d); check("R2 cause kept when disabled", d, 16'h0200);
        wr(1'b0, 2'b01, 16'h0002);
        wr(1'b0, 2'b10, 16'hFD00);
        check("R3 irq drops with cause clear", irq_req, 0);
        rd(1'b0, d); check("R7 zero clears cause", d, 16'h0002);

        // ---- R7: writing ones has no effect
        wr(1'b0, 2'b10, 16'hFF00);
        rd(1'b0, d); check("R7 ones do not set cause", d, 16'h0002);
        ext_in[1] = 1'b1; cyc(1); ext_in[1] = 1'b0; cyc(6);
        wr(1'b0, 2'b10, 16'hFF00);
        rd(1'b0, d); check("R7 ones keep set cause", d, 16'h0202);

        // ---- R8: combined clear and enable in one write
        wr(1'b0, 2'b11, 16'h00F0);
        rd(1'b0, d); check("R8 word write", d, 16'h00F0);
        check("R8 irq after word write", irq_req, 0);

        // ---- R9: detection beats clear; held request retriggers
        ext_in[1] = 1'b1; cyc(5);
        wr(1'b0, 2'b10, 16'h0000);
        rd(1'b0, d); check("R9 set wins over clear", d[15:8], 8'h02);
        ext_in[1] = 1'b0; cyc(4);
        wr(1'b0, 2'b10, 16'h0000);
        rd(1'b0, d); check("R9 clear after request dropped", d[15:8], 8'h00);

        // ---- R6: wake path
        wr(1'b0, 2'b01, 16'h0002);
        ext_in[1] = 1'b1; #1;
        check("R6 wake high level", wake_req, 1);
        ext_in[1] = 1'b0; #1;
        check("R6 wake follows pin", wake_req, 0);
        cyc(1);
        wr(1'b1, 2'b11, 16'hAAA2);                  // ch1 low level
        #1 check("R6 no wake in low mode", wake_req, 0);
        wr(1'b1, 2'b11, 16'hAAAA);                  // ch1 rising
        ext_in[1] = 1'b1; #1;
        check("R6 no wake in edge mode", wake_req, 0);
        cyc(1);
        wr(1'b1, 2'b11, 16'hAAA6);
        wr(1'b0, 2'b01, 16'h0000);
        #1 check("R6 no wake when disabled", wake_req, 0);
        ext_in[1] = 1'b0;

        // ---- R1: reset mid-operation
        wr(1'b0, 2'b01, 16'h00FF);
        ext_in[1] = 1'b1; cyc(5);
        rst = 1'b1; cyc(2);
        rd(1'b0, d); check("R1 reset clears live state", d, 16'h0000);
        rst = 1'b0; ext_in[1] = 1'b0;
        cyc(2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule